// File: doc/BRIEF.md
# Data Breakpoint Match Unit

This block holds a bank of programmable breakpoint pairs and checks every data memory access against all of them at once. Each pair has an address word and a qualifier word. The qualifier word carries a per-bit address mask, enables for read and write accesses, and one enable bit for each of the four privilege levels. The compare result for each pair is available in the same cycle as a hit vector. One cycle later the block gives a registered outcome. For a native access the outcome is a debug fault, or a deferral when the access is a speculative load. For a legacy-mode access the outcome is a trap, together with a status vector for the low four pairs.

Software programs the pairs through a simple indexed register port. Pair p uses index 2p for the address word and index 2p+1 for the qualifier word. The access port is presented once per memory reference. A global enable gates all matching. A one-shot suppression flag masks native faults until the end of the current instruction or register-stack reference. A deferral control turns faults on speculative loads into deferrals. A breakpoint address that lies outside the implemented address range never matches.

Top module: `dbm_unit`

## Requirements
- R1: While reset is asserted and after it is released, fault_o, defer_o, trap_o and trap_vec_o are 0. Every breakpoint word reads 0 and hit_vec_o is 0.
- R2: A write to index 2p stores the full 64-bit address of pair p, and the same index reads it back. A write to index 2p+1 stores the qualifier word, which reads back with bits 61:60 as 0. Indices at or above 2*NUM_PAIRS read 0.
- R3: Bit p of hit_vec_o, driven combinationally, requires that ((acc_addr_i ^ addr[55:0]) & mask) == 0, where mask is qualifier bits 55:0. Address bits whose mask bit is 0 do not take part in the compare.
- R4: A read access (acc_write_i=0) can only match a pair whose qualifier bit 63 is 1. A write access can only match a pair whose qualifier bit 62 is 1.
- R5: An access at privilege level n (acc_pl_i, 0..3) can only match a pair whose qualifier bit 56+n is 1.
- R6: A pair whose address word has any bit from IMPL_AW to 63 set never matches, even when its mask is all zero.
- R7: When dbg_en_i is 0, or when acc_valid_i is 0, hit_vec_o is 0 and no fault, defer or trap follows.
- R8: A native access (acc_legacy_i=0) with acc_qp_i=1 that hits any pair raises fault_o in the next cycle. With acc_qp_i=0 it raises nothing. At most one of fault_o, defer_o and trap_o is 1 in any cycle.
- R9: A hitting native speculative read (acc_spec_i=1, acc_write_i=0) with defer_en_i=1 raises defer_o instead of fault_o. With defer_en_i=0 it faults.
- R10: A pulse on oneshot_set_i sets a suppression flag. While the flag is set, native faults and deferrals are suppressed. An access with acc_end_i=1 clears the flag after it completes, so the next hitting access faults again.
- R11: A legacy-mode access that hits any pair raises trap_o in the next cycle, whatever acc_qp_i and the suppression flag are. trap_vec_o then holds the hit bits of pairs 0..3, which may be all zero. trap_vec_o is 0 whenever trap_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | IDX_W | Register index (2p address, 2p+1 qualifier) |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data at reg_addr_i |
| dbg_en_i | input | 1 | Global data-breakpoint enable |
| defer_en_i | input | 1 | Defer matches on speculative loads |
| oneshot_set_i | input | 1 | Sets the one-shot suppression flag |
| acc_valid_i | input | 1 | Access present this cycle |
| acc_addr_i | input | 56 | Access address |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_pl_i | input | 2 | Privilege level of the access |
| acc_qp_i | input | 1 | Qualifying predicate |
| acc_spec_i | input | 1 | Speculative access |
| acc_legacy_i | input | 1 | Legacy-mode access (trap semantics) |
| acc_end_i | input | 1 | Access ends its instruction or stack reference |
| hit_vec_o | output | NUM_PAIRS | Combinational per-pair match |
| fault_o | output | 1 | Registered native debug fault |
| defer_o | output | 1 | Registered deferral |
| trap_o | output | 1 | Registered legacy trap |
| trap_vec_o | output | 4 | Registered trap status of pairs 0..3 |

## Verification
The bound checker checks on every cycle that the three outcomes are mutually exclusive. It also checks that each registered fault, deferral or trap traces back to an access of the right kind in the previous cycle, that a trap vector never appears without a trap, and that the hit vector stays clear while matching is disabled. Only the bench scenarios can show the mask arithmetic, the privilege-bit selection, the never-match rule for unimplemented addresses, the qualifier readback, and the multi-access sequence of the one-shot flag, because each of these depends on programmed register contents or on history across several accesses.

// File: rtl/dbm_pkg.sv
package dbm_pkg;
  localparam int REG_W  = 64;
  localparam int MASK_W = 56;
  localparam int PLM_W  = 4;
  localparam int TVEC_W = 4;
  localparam int PL_W   = $clog2(PLM_W);

  typedef struct packed {
    logic              rd_en;
    logic              wr_en;
    logic [PLM_W-1:0]  plm;
    logic [MASK_W-1:0] mask;
  } bp_ctl_t;

  function automatic logic [REG_W-1:0] pack_ctl(bp_ctl_t c);
    return {c.rd_en, c.wr_en, 2'b00, c.plm, c.mask};
  endfunction

  function automatic bp_ctl_t unpack_ctl(logic [REG_W-1:0] w);
    bp_ctl_t c;
    c.rd_en = w[63];
    c.wr_en = w[62];
    c.plm   = w[59:56];
    c.mask  = w[55:0];
    return c;
  endfunction
endpackage

// File: rtl/dbm_regfile.sv
module dbm_regfile
  import dbm_pkg::*;
#(
  parameter int NUM_PAIRS = 6,
  localparam int IDX_W    = $clog2(2 * NUM_PAIRS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [REG_W-1:0]  bp_addr_o [NUM_PAIRS],
  output bp_ctl_t           bp_ctl_o  [NUM_PAIRS]
);

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    localparam logic [IDX_W-1:0] EVEN_IDX = IDX_W'(2 * p);
    localparam logic [IDX_W-1:0] ODD_IDX  = IDX_W'(2 * p + 1);

    logic [REG_W-1:0] addr_q;
    bp_ctl_t          ctl_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_q <= '0;
        ctl_q  <= '0;
      end else if (we_i) begin
        if (addr_i == EVEN_IDX) addr_q <= wdata_i;
        if (addr_i == ODD_IDX)  ctl_q  <= unpack_ctl(wdata_i);
      end
    end

    assign bp_addr_o[p] = addr_q;
    assign bp_ctl_o[p]  = ctl_q;
  end

  always_comb begin
    rdata_o = '0;
    for (int p = 0; p < NUM_PAIRS; p++) begin
      if (addr_i == IDX_W'(2 * p))     rdata_o = bp_addr_o[p];
      if (addr_i == IDX_W'(2 * p + 1)) rdata_o = pack_ctl(bp_ctl_o[p]);
    end
  end

endmodule

// File: rtl/dbm_pair_cmp.sv
module dbm_pair_cmp
  import dbm_pkg::*;
#(
  parameter int IMPL_AW = 48
) (
  input  logic              en_i,
  input  logic [REG_W-1:0]  bp_addr_i,
  input  bp_ctl_t           bp_ctl_i,
  input  logic [MASK_W-1:0] acc_addr_i,
  input  logic              acc_write_i,
  input  logic [PL_W-1:0]   acc_pl_i,
  output logic              hit_o
);

  logic addr_ok, impl_ok, type_ok, pl_ok;

  assign addr_ok = ((acc_addr_i ^ bp_addr_i[MASK_W-1:0]) & bp_ctl_i.mask) == '0;
  // addresses outside the implemented range are a guaranteed miss
  assign impl_ok = bp_addr_i[REG_W-1:IMPL_AW] == '0;
  assign type_ok = acc_write_i ? bp_ctl_i.wr_en : bp_ctl_i.rd_en;
  assign pl_ok   = bp_ctl_i.plm[acc_pl_i];

  assign hit_o = en_i & addr_ok & impl_ok & type_ok & pl_ok;

endmodule

// File: rtl/dbm_resolve.sv
module dbm_resolve
  import dbm_pkg::*;
#(
  parameter int NUM_PAIRS = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PAIRS-1:0] hit_i,
  input  logic                 defer_en_i,
  input  logic                 oneshot_set_i,
  input  logic                 acc_valid_i,
  input  logic                 acc_write_i,
  input  logic                 acc_qp_i,
  input  logic                 acc_spec_i,
  input  logic                 acc_legacy_i,
  input  logic                 acc_end_i,
  output logic                 fault_o,
  output logic                 defer_o,
  output logic                 trap_o,
  output logic [TVEC_W-1:0]    trap_vec_o
);

  logic any_hit, native_hit, defer_d, fault_d, trap_d, ss_q;
  logic [TVEC_W-1:0] tvec_d;

  assign any_hit    = |hit_i;
  assign native_hit = acc_valid_i & ~acc_legacy_i & acc_qp_i & any_hit & ~ss_q;
  assign defer_d    = native_hit & acc_spec_i & ~acc_write_i & defer_en_i;
  assign fault_d    = native_hit & ~defer_d;
  assign trap_d     = acc_valid_i & acc_legacy_i & any_hit;
  assign tvec_d     = trap_d ? hit_i[TVEC_W-1:0] : '0;

  // set takes priority; the access in flight still sees the old flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      ss_q <= 1'b0;
    else if (oneshot_set_i)           ss_q <= 1'b1;
    else if (acc_valid_i & acc_end_i) ss_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_o    <= 1'b0;
      defer_o    <= 1'b0;
      trap_o     <= 1'b0;
      trap_vec_o <= '0;
    end else begin
      fault_o    <= fault_d;
      defer_o    <= defer_d;
      trap_o     <= trap_d;
      trap_vec_o <= tvec_d;
    end
  end

endmodule

// File: rtl/dbm_unit.sv
module dbm_unit
  import dbm_pkg::*;
#(
  parameter int NUM_PAIRS = 6,
  parameter int IMPL_AW   = 48,
  localparam int IDX_W    = $clog2(2 * NUM_PAIRS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic [IDX_W-1:0]     reg_addr_i,
  input  logic [63:0]          reg_wdata_i,
  output logic [63:0]          reg_rdata_o,
  input  logic                 dbg_en_i,
  input  logic                 defer_en_i,
  input  logic                 oneshot_set_i,
  input  logic                 acc_valid_i,
  input  logic [55:0]          acc_addr_i,
  input  logic                 acc_write_i,
  input  logic [1:0]           acc_pl_i,
  input  logic                 acc_qp_i,
  input  logic                 acc_spec_i,
  input  logic                 acc_legacy_i,
  input  logic                 acc_end_i,
  output logic [NUM_PAIRS-1:0] hit_vec_o,
  output logic                 fault_o,
  output logic                 defer_o,
  output logic                 trap_o,
  output logic [3:0]           trap_vec_o
);

  logic [REG_W-1:0] bp_addr [NUM_PAIRS];
  bp_ctl_t          bp_ctl  [NUM_PAIRS];
  logic             cmp_en;

  assign cmp_en = dbg_en_i & acc_valid_i;

  dbm_regfile #(.NUM_PAIRS(NUM_PAIRS)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .bp_addr_o(bp_addr),
    .bp_ctl_o (bp_ctl)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_cmp
    dbm_pair_cmp #(.IMPL_AW(IMPL_AW)) u_cmp (
      .en_i       (cmp_en),
      .bp_addr_i  (bp_addr[p]),
      .bp_ctl_i   (bp_ctl[p]),
      .acc_addr_i (acc_addr_i),
      .acc_write_i(acc_write_i),
      .acc_pl_i   (acc_pl_i),
      .hit_o      (hit_vec_o[p])
    );
  end

  dbm_resolve #(.NUM_PAIRS(NUM_PAIRS)) u_res (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hit_i        (hit_vec_o),
    .defer_en_i   (defer_en_i),
    .oneshot_set_i(oneshot_set_i),
    .acc_valid_i  (acc_valid_i),
    .acc_write_i  (acc_write_i),
    .acc_qp_i     (acc_qp_i),
    .acc_spec_i   (acc_spec_i),
    .acc_legacy_i (acc_legacy_i),
    .acc_end_i    (acc_end_i),
    .fault_o      (fault_o),
    .defer_o      (defer_o),
    .trap_o       (trap_o),
    .trap_vec_o   (trap_vec_o)
  );

endmodule

// File: rtl/dbm_unit_chk.sv
module dbm_unit_chk #(
  parameter int NUM_PAIRS = 6
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 dbg_en_i,
  input logic                 defer_en_i,
  input logic                 acc_valid_i,
  input logic                 acc_write_i,
  input logic                 acc_qp_i,
  input logic                 acc_spec_i,
  input logic                 acc_legacy_i,
  input logic [NUM_PAIRS-1:0] hit_vec_o,
  input logic                 fault_o,
  input logic                 defer_o,
  input logic                 trap_o,
  input logic [3:0]           trap_vec_o
);

  // R7
  hit_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dbg_en_i && acc_valid_i) |-> hit_vec_o == '0);

  // R8
  outcome_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fault_o, defer_o, trap_o}));

  // R8
  fault_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $past(acc_valid_i && dbg_en_i && !acc_legacy_i && acc_qp_i));

  // R9
  defer_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    defer_o |-> $past(acc_valid_i && acc_spec_i && !acc_write_i && defer_en_i && !acc_legacy_i));

  // R11
  trap_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> $past(acc_valid_i && dbg_en_i && acc_legacy_i));

  // R11
  tvec_only_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_vec_o != '0) |-> trap_o);

endmodule

bind dbm_unit dbm_unit_chk #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dbg_en_i    (dbg_en_i),
  .defer_en_i  (defer_en_i),
  .acc_valid_i (acc_valid_i),
  .acc_write_i (acc_write_i),
  .acc_qp_i    (acc_qp_i),
  .acc_spec_i  (acc_spec_i),
  .acc_legacy_i(acc_legacy_i),
  .hit_vec_o   (hit_vec_o),
  .fault_o     (fault_o),
  .defer_o     (defer_o),
  .trap_o      (trap_o),
  .trap_vec_o  (trap_vec_o)
);

// File: tb/tb_dbm_unit.sv
module tb_dbm_unit;
  localparam int CLK_P = 10;
  localparam int NP    = 6;
  localparam int IW    = $clog2(2 * NP);
  localparam int VW    = 75;
  localparam int NV    = 12;

  // wr | pl | qp | spec | leg | addr56 | hit6 | fault | defer | trap | tvec4
  localparam logic [VW-1:0] VECS [NV] = '{
    {1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 56'h1008, 6'b000001, 1'b1, 1'b0, 1'b0, 4'b0000},
    {1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 56'h1008, 6'b000000, 1'b0, 1'b0, 1'b0, 4'b0000},
    {1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 56'h2010, 6'b010010, 1'b1, 1'b0, 1'b0, 4'b0000},
    {1'b0, 2'd3, 1'b1, 1'b0, 1'b0, 56'h2010, 6'b010000, 1'b1, 1'b0, 1'b0, 4'b0000},
    {1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 56'h3000, 6'b000100, 1'b0, 1'b0, 1'b0, 4'b0000},
    {1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 56'h100F, 6'b000001, 1'b1, 1'b0, 1'b0, 4'b0000},
    {1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 56'h1004, 6'b000001, 1'b0, 1'b1, 1'b0, 4'b0000},
    {1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 56'h3000, 6'b000100, 1'b1, 1'b0, 1'b0, 4'b0000},
    {1'b0, 2'd3, 1'b0, 1'b0, 1'b1, 56'h2010, 6'b010000, 1'b0, 1'b0, 1'b1, 4'b0000},
    {1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 56'h2010, 6'b010010, 1'b0, 1'b0, 1'b1, 4'b0010},
    {1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 56'h1000, 6'b000000, 1'b0, 1'b0, 1'b0, 4'b0000},
    {1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 56'h2FF0, 6'b000010, 1'b1, 1'b0, 1'b0, 4'b0000}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_we_i = 1'b0;
  logic [IW-1:0] reg_addr_i = '0;
  logic [63:0]   reg_wdata_i = '0;
  logic [63:0]   reg_rdata_o;
  logic          dbg_en_i = 1'b0, defer_en_i = 1'b0, oneshot_set_i = 1'b0;
  logic          acc_valid_i = 1'b0, acc_write_i = 1'b0;
  logic [55:0]   acc_addr_i = '0;
  logic [1:0]    acc_pl_i = '0;
  logic          acc_qp_i = 1'b0, acc_spec_i = 1'b0, acc_legacy_i = 1'b0, acc_end_i = 1'b0;
  logic [NP-1:0] hit_vec_o;
  logic          fault_o, defer_o, trap_o;
  logic [3:0]    trap_vec_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;
  logic [NP-1:0] hit_s;

  always #(CLK_P / 2) clk_i = ~clk_i;

  dbm_unit #(.NUM_PAIRS(NP), .IMPL_AW(48)) dut (.*);

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int idx, input logic [63:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = IW'(idx); reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd_reg(input int idx, output logic [63:0] d);
    @(negedge clk_i);
    reg_addr_i = IW'(idx);
    #1 d = reg_rdata_o;
  endtask

  task automatic do_acc(input logic wr, input logic [1:0] pl, input logic qp, input logic sp,
                        input logic lg, input logic en, input logic [55:0] a);
    @(negedge clk_i);
    acc_valid_i = 1'b1; acc_write_i = wr; acc_pl_i = pl; acc_qp_i = qp;
    acc_spec_i = sp; acc_legacy_i = lg; acc_end_i = en; acc_addr_i = a;
    #1 hit_s = hit_vec_o;
    @(posedge clk_i);
    #1;
    @(negedge clk_i);
    acc_valid_i = 1'b0; acc_end_i = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  // Outputs are checked right after the access's capturing edge: do_acc
  // returns at the following negedge, and the registered outputs stay valid
  // there because acc_valid_i drops only at that negedge.
  initial begin
    logic [63:0] rd;
    #(CLK_P * 3);
    // R1 during reset
    check({fault_o, defer_o, trap_o, trap_vec_o} == '0, "R1 outs in reset", {fault_o, defer_o, trap_o, trap_vec_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    rd_reg(1, rd);
    check(rd == 0, "R1 qual reset", rd, 0);
    check(hit_vec_o == 0 && fault_o == 0, "R1 hit after reset", hit_vec_o, 0);

    wr_reg(0, 64'h1000);                wr_reg(1, 64'h8FFF_FFFF_FFFF_FFF0);
    wr_reg(2, 64'h2000);                wr_reg(3, 64'hF1FF_FFFF_FFFF_F000);
    wr_reg(4, 64'h3000);                wr_reg(5, 64'h4FFF_FFFF_FFFF_FFFF);
    wr_reg(6, 64'h0001_0000_0000_0000); wr_reg(7, 64'hCF00_0000_0000_0000);
    wr_reg(8, 64'h2010);                wr_reg(9, 64'hCFFF_FFFF_FFFF_FFFF);

    // R2 readback
    rd_reg(3, rd);
    check(rd == 64'hC1FF_FFFF_FFFF_F000, "R2 qual readback", rd, 64'hC1FF_FFFF_FFFF_F000);
    rd_reg(8, rd);
    check(rd == 64'h2010, "R2 addr readback", rd, 64'h2010);
    rd_reg(13, rd);
    check(rd == 0, "R2 out of range", rd, 0);

    dbg_en_i = 1'b1; defer_en_i = 1'b1;
    // table: R3 R4 R5 R6 R8 R9 R11
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VECS[i];
      do_acc(v[74], v[73:72], v[71], v[70], v[69], 1'b1, v[68:13]);
      check(hit_s == v[12:7], $sformatf("R3 R4 R5 R6 hit vec %0d", i), hit_s, v[12:7]);
      check({fault_o, defer_o, trap_o, trap_vec_o} == v[6:0],
            $sformatf("R8 R9 R11 outcome vec %0d", i), {fault_o, defer_o, trap_o, trap_vec_o}, v[6:0]);
    end

    // R6 contrast: same pair matches once its address is implemented
    wr_reg(6, 64'h0);
    do_acc(1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 56'h5555);
    check(hit_s == 6'b001000 && fault_o, "R6 implemented addr hits", hit_s, 6'b001000);
    wr_reg(6, 64'h8000_0000_0000_0000);
    do_acc(1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 56'h5555);
    check(hit_s == 0 && !fault_o, "R6 top bit never hits", hit_s, 0);

    // R7 global enable off
    dbg_en_i = 1'b0;
    do_acc(1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 56'h1008);
    check(hit_s == 0 && !fault_o, "R7 disabled", {hit_s, fault_o}, 0);
    dbg_en_i = 1'b1;

    // R9 deferral disabled -> fault
    defer_en_i = 1'b0;
    do_acc(1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 56'h1004);
    check(fault_o && !defer_o, "R9 no defer when off", {fault_o, defer_o}, 2'b10);
    defer_en_i = 1'b1;

    // R10 one-shot sequence
    @(negedge clk_i); oneshot_set_i = 1'b1;
    @(negedge clk_i); oneshot_set_i = 1'b0;
    do_acc(1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 56'h2010);
    check(trap_o && trap_vec_o == 4'b0010, "R10 R11 trap not suppressed", {trap_o, trap_vec_o}, 5'b10010);
    do_acc(1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 56'h1008);
    check(!fault_o, "R10 fault suppressed", fault_o, 0);
    do_acc(1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 56'h1004);
    check(!fault_o && !defer_o, "R10 defer suppressed", {fault_o, defer_o}, 0);
    do_acc(1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 56'h1008);
    check(fault_o, "R10 flag cleared", fault_o, 1);

    @(negedge clk_i);
    @(negedge clk_i);
    check({fault_o, defer_o, trap_o} == 0, "R8 idle no outcome", {fault_o, defer_o, trap_o}, 0);
    summary();
  end

  initial begin
    #(CLK_P * 200000);
    n_err++;
    $display("FAIL watchdog act=timeout exp=finish");
    summary();
  end
endmodule